// File: doc/BRIEF.md
# Multi-Mode Limit Counter Timer

This block is a register-mapped up-counter. It advances once per qualified tick while running and compares itself against a programmable limit. When the counter reaches the compare value it wraps to zero and keeps counting, which makes it periodic. It also sets a sticky "reached" flag and, unless the timer is in the free-running user mode, raises a level interrupt. Software acknowledges the event by reading the limit register, which lowers the interrupt and clears the flag.

The timer has three modes. A processor-local timer can be switched at run time between processor mode and user mode. A system timer is fixed in system mode from reset and ignores mode writes. The compare value is the limit register shifted right by `CMP_SHIFT` bits (default 9), so one compare step equals 2^`CMP_SHIFT` limit units. With a 500 ns tick the limit then reads in units of roughly one nanosecond. Register accesses are single-cycle with word offsets and need no handshake. A read returns combinational data in the cycle `rd_en` is high, and its side effect lands at the following clock edge. `RESET_MODE` must be 0 (processor) or 2 (system).

Top module: `lim_timer`

## Requirements
- R1: After reset the timer is stopped, the interrupt is low, the counter, limit and reached flag are zero, and the mode equals `RESET_MODE`.
- R2: While running, each clock with `tick_en` high advances the counter by one. Reading offset 1 returns the reached flag in bit 31 and the counter in the low bits, with zeros between them.
- R3: The compare value is `limit >> CMP_SHIFT`. A tick that takes the counter to a value at or above a non-zero compare value sets the reached flag and wraps the counter to zero. With a zero compare value the counter wraps only at its own width.
- R4: A reach event raises `irq` in processor mode (0) and system mode (2), and never in user mode (1). The mode used is the one held before that clock edge.
- R5: Reading offset 0 returns the limit with bit 31 forced to zero. Outside user mode this read clears the reached flag and lowers `irq` at the next edge. In user mode it has no side effect. A reach event in the same cycle takes precedence over the clear.
- R6: Writing offset 0 loads the limit, clears the counter and lowers `irq`. It overrides a tick in the same cycle, and it leaves the reached flag unchanged.
- R7: Writing offset 2 loads the limit and leaves the counter unchanged. Reading offset 2 returns all 32 limit bits with no side effect.
- R8: Offset 4 reads the mode in bits 1:0 (0 processor, 1 user, 2 system). A write is honoured only when the current mode is 0 or 1, and it sets the mode to bit 0 of the data. A system-mode timer keeps its mode forever.
- R9: A mode write that results in user mode lowers `irq` and sets the limit to all ones.
- R10: Offset 3 holds the run control in bit 0 (1 runs, 0 stops). While stopped, the counter holds regardless of `tick_en`.
- R11: Offsets 5 to 7 read as zero and ignore writes. `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count qualifier, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the collisions inside a single clock edge. One case is a reload write landing on a tick: a design that lets the tick win would show a counter of one. Another is a limit rewritten below the current count: a design using an equality compare would run a full wrap before reporting. A third is an acknowledge read in user mode, where a design that clears anyway would lose the reached flag. The bench also checks that entering user mode drops a pending interrupt and forces the limit to all ones, and that a system timer rejects mode writes. A design wrong on the last two points would leave `irq` high in user mode or turn the system timer quiet. A second instance reset into system mode runs alongside the first on the same stimulus, so every divergence between the modes is compared on every clock.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_CPU  = 2'd0,
    MODE_USER = 2'd1,
    MODE_SYS  = 2'd2
  } tmr_mode_e;

  // word offsets; offset 0 vs 2 selects reload behaviour
  localparam int OFS_LIM_RELOAD = 0;
  localparam int OFS_COUNT      = 1;
  localparam int OFS_LIM_KEEP   = 2;
  localparam int OFS_RUN        = 3;
  localparam int OFS_MODE       = 4;

  typedef struct packed {
    logic reload;      // limit write that restarts the count
    logic ack;         // acknowledging read of the limit
    logic enter_user;  // mode write landing in user mode
  } tmr_evt_t;
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int AW         = 3,
  parameter int CNT_W      = 23,
  parameter int RESET_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              reached,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] limit_q,
  output tmr_mode_e         mode_q,
  output logic              run_q,
  output tmr_evt_t          evt
);
  localparam logic [AW-1:0] A_RELOAD = AW'(OFS_LIM_RELOAD);
  localparam logic [AW-1:0] A_COUNT  = AW'(OFS_COUNT);
  localparam logic [AW-1:0] A_KEEP   = AW'(OFS_LIM_KEEP);
  localparam logic [AW-1:0] A_RUN    = AW'(OFS_RUN);
  localparam logic [AW-1:0] A_MODE   = AW'(OFS_MODE);
  localparam tmr_mode_e     MODE_RST = tmr_mode_e'(RESET_MODE[1:0]);

  logic              mode_writable;
  logic              mode_wr;
  logic              limit_wr;
  logic [DATA_W-1:0] cnt_field;
  logic [DATA_W-1:0] rd_mux;

  assign mode_writable  = (mode_q == MODE_CPU) || (mode_q == MODE_USER);
  assign mode_wr        = wr_en && (addr == A_MODE) && mode_writable;
  assign limit_wr       = wr_en && ((addr == A_RELOAD) || (addr == A_KEEP));
  assign evt.reload     = wr_en && (addr == A_RELOAD);
  assign evt.enter_user = mode_wr && wdata[0];
  assign evt.ack        = rd_en && (addr == A_RELOAD) && (mode_q != MODE_USER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      mode_q  <= MODE_RST;
      run_q   <= 1'b0;
    end else begin
      if (evt.enter_user)
        limit_q <= '1;
      else if (limit_wr)
        limit_q <= wdata;
      if (mode_wr)
        mode_q <= wdata[0] ? MODE_USER : MODE_CPU;
      if (wr_en && (addr == A_RUN))
        run_q <= wdata[0];
    end
  end

  generate
    if (DATA_W - 1 > CNT_W) begin : g_pad
      assign cnt_field = {reached, {(DATA_W-1-CNT_W){1'b0}}, cnt};
    end else begin : g_nopad
      assign cnt_field = {reached, cnt};
    end
  endgenerate

  always_comb begin
    case (addr)
      A_RELOAD: rd_mux = {1'b0, limit_q[DATA_W-2:0]};
      A_COUNT:  rd_mux = cnt_field;
      A_KEEP:   rd_mux = limit_q;
      A_RUN:    rd_mux = {{(DATA_W-1){1'b0}}, run_q};
      A_MODE:   rd_mux = {{(DATA_W-2){1'b0}}, mode_q};
      default:  rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  logic             step;
  logic [CNT_W:0]   nxt;

  assign step = run && tick_en && !reload;
  assign nxt  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // at-or-above compare catches a limit lowered beneath the running count
  assign hit  = step && (cmp != '0) && (nxt >= {1'b0, cmp});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (reload || hit)
      cnt_q <= '0;
    else if (step)
      cnt_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic in_user,
  input  logic ack,
  input  logic lower,
  output logic reached_q,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (hit)
        reached_q <= 1'b1;
      else if (ack)
        reached_q <= 1'b0;

      if (lower)
        irq_q <= 1'b0;
      else if (hit && !in_user)
        irq_q <= 1'b1;
      else if (ack)
        irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lim_timer.sv
`timescale 1ns/1ps
module lim_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int AW         = 3,
  parameter int CMP_SHIFT  = 9,
  parameter int RESET_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = DATA_W - CMP_SHIFT;

  logic [DATA_W-1:0] limit_q;
  tmr_mode_e         mode_q;
  logic              run_q;
  tmr_evt_t          evt;
  logic [CNT_W-1:0]  cnt_q;
  logic              hit;
  logic              reached_q;
  logic              irq_q;

  tmr_regs #(
    .DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W), .RESET_MODE(RESET_MODE)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_q), .reached(reached_q), .rdata(rdata),
    .limit_q(limit_q), .mode_q(mode_q), .run_q(run_q), .evt(evt)
  );

  tmr_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run_q),
    .reload(evt.reload), .cmp(limit_q[DATA_W-1 -: CNT_W]),
    .cnt_q(cnt_q), .hit(hit)
  );

  tmr_flag flag_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .in_user(mode_q == MODE_USER),
    .ack(evt.ack), .lower(evt.reload || evt.enter_user),
    .reached_q(reached_q), .irq_q(irq_q)
  );

  assign irq = irq_q;
endmodule

// File: rtl/lim_timer_chk.sv
`timescale 1ns/1ps
module lim_timer_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 3,
  parameter int CNT_W  = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              reached,
  input logic [CNT_W-1:0]  cnt,
  input tmr_mode_e         mode,
  input logic              run
);
  localparam logic [AW-1:0] A_RELOAD = AW'(OFS_LIM_RELOAD);
  localparam logic [AW-1:0] A_LAST   = AW'(OFS_MODE);

  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> reached && ($past(mode) != MODE_USER));

  assert_user_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_USER) |-> !irq);

  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && addr == A_RELOAD)) |=> $stable(cnt));

  assert_reload_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_RELOAD) |=> (cnt == '0) && !irq);

  assert_sys_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SYS) |=> (mode == MODE_SYS));

  assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > A_LAST) |-> (rdata == '0));

  assert_reach_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reached) |-> (cnt == '0));
endmodule

bind lim_timer lim_timer_chk #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq(irq), .reached(reached_q), .cnt(cnt_q),
  .mode(mode_q), .run(run_q)
);

// File: tb/lim_timer_tb_top.sv
`timescale 1ns/1ps
module lim_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_s;
  logic        irq_a, irq_s;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  lim_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_a), .irq(irq_a)
  );

  lim_timer #(.RESET_MODE(2)) dut_sys_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_s), .irq(irq_s)
  );

  // behavioural reference, index 0 = processor timer, 1 = system timer
  logic [31:0] m_lim [2];
  logic [22:0] m_cnt [2];
  int          m_mode[2];
  bit          m_run [2];
  bit          m_irq [2];
  bit          m_rch [2];

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      m_lim[i] = 0; m_cnt[i] = 0; m_mode[i] = (i == 0) ? 0 : 2;
      m_run[i] = 0; m_irq[i] = 0; m_rch[i] = 0;
    end
  endfunction

  function automatic void model_step(int i);
    bit          w0   = wr_en && addr == 0;
    int unsigned cmp  = m_lim[i] >> 9;
    bit          go   = m_run[i] && tick_en && !w0;
    longint      nx   = longint'(m_cnt[i]) + 1;
    bit          hit  = go && cmp != 0 && nx >= cmp;
    bit          wok  = m_mode[i] <= 1;
    bit          ent  = wr_en && addr == 4 && wok && wdata[0];
    bit          ack  = rd_en && addr == 0 && m_mode[i] != 1;
    if (w0 || ent) m_irq[i] = 0;
    else if (hit && m_mode[i] != 1) m_irq[i] = 1;
    else if (ack) m_irq[i] = 0;
    if (hit) m_rch[i] = 1;
    else if (ack) m_rch[i] = 0;
    if (w0 || hit) m_cnt[i] = 0;
    else if (go) m_cnt[i] = nx[22:0];
    if (ent) m_lim[i] = '1;
    else if (wr_en && (addr == 0 || addr == 2)) m_lim[i] = wdata;
    if (wr_en && addr == 4 && wok) m_mode[i] = wdata[0];
    if (wr_en && addr == 3) m_run[i] = wdata[0];
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    if (!rd_en) return 32'h0;
    case (addr)
      3'd0: return {1'b0, m_lim[i][30:0]};
      3'd1: return {m_rch[i], 8'h00, m_cnt[i]};
      3'd2: return m_lim[i];
      3'd3: return {31'h0, m_run[i]};
      3'd4: return 32'(m_mode[i]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (addr)
      3'd0: return "R5";
      3'd1: return "R2";
      3'd2: return "R7";
      3'd3: return "R10";
      3'd4: return "R8";
      default: return "R11";
    endcase
  endfunction

  // per-clock comparison against the reference
  always begin
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      model_step(0);
      model_step(1);
    end
    #5;
    if (rst_n && !done) begin
      check("R4 cycle irq cpu", {31'h0, irq_a}, {31'h0, m_irq[0]});
      check("R4 cycle irq sys", {31'h0, irq_s}, {31'h0, m_irq[1]});
      check({rd_tag(), " cycle rdata cpu"}, rdata_a, exp_rd(0));
      check({rd_tag(), " cycle rdata sys"}, rdata_s, exp_rd(1));
    end
  end

  task automatic op(bit w, bit r, int a, logic [31:0] d, bit t);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a[2:0]; wdata = d; tick_en = t;
  endtask

  task automatic wr(int a, logic [31:0] d);
    op(1, 0, a, d, 0);
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) op(0, 0, 0, 0, 1);
  endtask

  task automatic rdc(int a, logic [31:0] ea, logic [31:0] es, string tag);
    op(0, 1, a, 0, 0);
    #5;
    check({tag, " read cpu"}, rdata_a, ea);
    check({tag, " read sys"}, rdata_s, es);
  endtask

  task automatic irqc(bit ea, bit es, string tag);
    op(0, 0, 0, 0, 0);
    #5;
    check({tag, " irq cpu"}, {31'h0, irq_a}, {31'h0, ea});
    check({tag, " irq sys"}, {31'h0, irq_s}, {31'h0, es});
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdc(3, 0, 0, "R1 run");
    rdc(1, 0, 0, "R1 count");
    rdc(2, 0, 0, "R1 limit");
    rdc(4, 0, 2, "R1 mode");
    irqc(0, 0, "R1");

    // R2 / R3 / R4 basic periodic reach, compare value 3
    wr(0, 32'h600);
    wr(3, 1);
    tick(2);
    rdc(1, 2, 2, "R2 count two");
    tick(1);
    irqc(1, 1, "R4 raise");
    rdc(1, 32'h8000_0000, 32'h8000_0000, "R3 wrap");
    rdc(0, 32'h600, 32'h600, "R5 ack value");
    rdc(1, 0, 0, "R5 flag cleared");
    irqc(0, 0, "R5 lowered");

    // R7 limit lowered beneath the count, no reload
    tick(2);
    wr(2, 32'h200);
    rdc(1, 2, 2, "R7 count kept");
    rdc(2, 32'h200, 32'h200, "R7 full limit");
    tick(1);
    rdc(1, 32'h8000_0000, 32'h8000_0000, "R3 at-or-above");
    irqc(1, 1, "R4 second");

    // R6 reload write colliding with a tick
    op(1, 0, 0, 32'hA00, 1);
    rdc(1, 32'h8000_0000, 32'h8000_0000, "R6 count zero");
    irqc(0, 0, "R6 lowered");
    rdc(0, 32'hA00, 32'hA00, "R6 limit");

    // R10 stopped counter ignores ticks
    wr(3, 0);
    tick(4);
    rdc(1, 0, 0, "R10 held");
    rdc(3, 0, 0, "R10 run bit");

    // R8 / R9 user mode
    wr(4, 1);
    rdc(4, 1, 2, "R8 mode write");
    rdc(2, 32'hFFFF_FFFF, 32'hA00, "R9 limit ones");
    wr(0, 32'h400);
    wr(3, 1);
    tick(2);
    irqc(0, 1, "R4 user silent");
    rdc(1, 32'h8000_0000, 32'h8000_0000, "R3 user reach");
    rdc(0, 32'h400, 32'h400, "R5 user read");
    rdc(1, 32'h8000_0000, 0, "R5 user no clear");
    wr(4, 0);
    rdc(4, 0, 2, "R8 back to cpu");
    tick(2);
    irqc(1, 1, "R4 cpu again");
    wr(4, 1);
    irqc(0, 1, "R9 irq dropped");
    rdc(2, 32'hFFFF_FFFF, 32'h400, "R9 limit forced");
    wr(4, 0);
    wr(0, 32'h400);

    // R11 holes and idle read data
    wr(5, 32'h1234);
    wr(7, 32'hFFFF);
    rdc(5, 0, 0, "R11 hole five");
    rdc(7, 0, 0, "R11 hole seven");
    rdc(2, 32'h400, 32'h400, "R11 limit untouched");
    op(0, 0, 2, 0, 0);
    #5;
    check("R11 idle rdata cpu", rdata_a, 0);
    check("R11 idle rdata sys", rdata_s, 0);

    // R5 bit 31 masked on the acknowledging read
    wr(2, 32'h8000_0400);
    rdc(0, 32'h400, 32'h400, "R5 mask");
    rdc(2, 32'h8000_0400, 32'h8000_0400, "R7 bit31 kept");
    wr(0, 32'h400);

    // mixed traffic, checked by the per-clock reference
    for (int n = 0; n < 4000; n++) begin
      int unsigned sel = $urandom % 10;
      logic [31:0] d = (($urandom % 6) << 9) | ($urandom & 32'h1FF);
      op(sel < 3, sel >= 3 && sel < 6, $urandom % 8, d, ($urandom % 10) < 7);
    end
    op(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule